// File: doc/BRIEF.md
# Per-Pin Edge and Level Interrupt Detector

This block watches one bank of 32 general-purpose input pins, arranged as 4 ports of 8 pins. Each pin passes through a two-stage synchronizer. A per-pin trigger condition is then applied to the synchronized value. The condition can be a rising edge, a falling edge, either edge, a high level or a low level.

Every pin owns a status bit and an enable bit. The single bank interrupt line is asserted when any pin has both its status bit and its enable bit set.

Software reaches the block through a simple word-addressed register bus:

- A write strobe and a read strobe select the operation.
- Read data is returned one cycle after the read strobe.
- The word address carries a 4-bit register selector in its upper bits and the port number in its two low bits.
- The byte offset is four times the word address.

Edge-triggered status is cleared through a write-one-to-clear register. Enables and the polarity byte of the trigger word can also be changed one pin at a time through masked-write windows. A masked write touches neighbouring pins only where the mask selects them.

Top module: `gpio_irq_bank`

## Requirements
- R1: Each port has a 24-bit trigger word. For pin n, bit n is polarity, bit 8+n selects edge mode and bit 16+n selects both edges. The encodings are: rising = bits 8+n and n set; falling = bit 8+n only; both edges = bits 16+n and 8+n; high level = bit n only; low level = all three bits clear. The word reads back exactly as written.
- R2: A pin in rising mode sets its status bit when its synchronized input goes from 0 to 1. The bit stays set after the input returns to 0, until it is cleared.
- R3: A pin in falling mode ignores a 0-to-1 transition and sets its status bit on a 1-to-0 transition.
- R4: A pin in both-edges mode sets its status bit on either transition.
- R5: In a level mode, the status bit follows whether the synchronized input is at the active level. A clear has no lasting effect while the level stays active.
- R6: Writing the clear register (byte offset 0x70 + 4·port) clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R7: If an edge-mode pin sees a new qualifying edge in the same cycle that it is cleared, its status bit stays set.
- R8: The bank interrupt output is high exactly when some pin, on any of the four ports, has both its status bit and its enable bit set. It follows that condition one cycle later.
- R9: The masked enable window (byte offset 0xD0 + 4·port) updates enable bit n to data bit n only where data bit 8+n is 1. Every other enable bit is kept.
- R10: The masked trigger window (byte offset 0xE0 + 4·port) updates polarity bit n to data bit n only where data bit 8+n is 1. Bits 8 to 23 of the trigger word are kept.
- R11: After reset, all enables and all trigger words are 0, and the interrupt output is 0.
- R12: Status (0x40 + 4·port), enable (0x50 + 4·port) and trigger (0x60 + 4·port) are readable, with data returned the cycle after the read strobe. Writes to the status register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Asynchronous pin levels, pin 8·port+n |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Word address: [5:2] register selector, [1:0] port |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Combined bank interrupt |

## Verification
The per-cycle properties cover the following:

- An edge-mode status bit is held until it is cleared.
- A clear that lands together with a new edge loses to the edge.
- A cleared bit with no new edge drops.
- A level-mode bit tracks the active level one cycle later.
- A masked enable write leaves unselected pins unchanged.
- The interrupt never rises without some enable set.
- Reset leaves enables, trigger words and the interrupt at 0.

Only the bench scenarios can show the rest, because it depends on full register-bus sequences. This covers the trigger encodings reading back correctly, the falling and both-edges selections responding to the right transitions, the masked trigger window sparing the upper bytes, and status ignoring writes. It also covers the interrupt combining pins from different ports.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Register selector carried in bus_addr[5:2]
  typedef enum logic [3:0] {
    SEL_STATUS   = 4'h4,
    SEL_ENABLE   = 4'h5,
    SEL_TRIG     = 4'h6,
    SEL_CLEAR    = 4'h7,
    SEL_EN_MASK  = 4'hD,
    SEL_TRIG_MSK = 4'hE
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int PINS   = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   pin_now,
  input  logic              we_en,
  input  logic              we_en_msk,
  input  logic              we_trig,
  input  logic              we_trig_msk,
  input  logic              we_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic [PINS-1:0]   status,
  output logic [PINS-1:0]   enable,
  output logic [3*PINS-1:0] trig,
  output logic              pend
);
  logic [PINS-1:0] pin_prev;
  logic [PINS-1:0] hit;
  logic [PINS-1:0] active;
  logic [PINS-1:0] is_edge;
  logic [PINS-1:0] st_next;
  logic [PINS-1:0] clr_bits;
  logic [PINS-1:0] wmask;
  logic [PINS-1:0] wval;

  assign wval     = wdata[PINS-1:0];
  assign wmask    = wdata[PINS +: PINS];
  assign clr_bits = we_clr ? wval : '0;

  always_ff @(posedge clk) begin
    if (rst) pin_prev <= '0;
    else     pin_prev <= pin_now;
  end

  generate
    for (genvar i = 0; i < PINS; i++) begin : g_pin
      logic pol, edg, both, rise, fall;
      assign pol  = trig[i];
      assign edg  = trig[PINS + i];
      assign both = trig[2*PINS + i];
      assign rise = pin_now[i] & ~pin_prev[i];
      assign fall = ~pin_now[i] & pin_prev[i];
      assign is_edge[i] = edg;
      assign active[i]  = pol ? pin_now[i] : ~pin_now[i];
      assign hit[i]     = both ? (rise | fall) : (pol ? rise : fall);
      assign st_next[i] = edg ? ((status[i] & ~clr_bits[i]) | hit[i]) : active[i];

      p_edge_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (is_edge[i] && status[i] && !clr_bits[i]) |=> status[i]);
      p_clear_race_r7: assert property (@(posedge clk) disable iff (rst)
        (is_edge[i] && hit[i] && clr_bits[i]) |=> status[i]);
      p_clear_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (is_edge[i] && clr_bits[i] && !hit[i]) |=> !status[i]);
      p_level_follow_r5: assert property (@(posedge clk) disable iff (rst)
        (!is_edge[i]) |=> (status[i] == $past(active[i])));
      p_mask_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (we_en_msk && !we_en && !wmask[i]) |=> (enable[i] == $past(enable[i])));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      trig   <= '0;
      pend   <= 1'b0;
    end else begin
      status <= st_next;
      pend   <= |(status & enable);
      if (we_en)
        enable <= wval;
      else if (we_en_msk)
        enable <= (enable & ~wmask) | (wval & wmask);
      if (we_trig)
        trig <= wdata[3*PINS-1:0];
      else if (we_trig_msk)
        trig[PINS-1:0] <= (trig[PINS-1:0] & ~wmask) | (wval & wmask);
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int PORTS       = 4,
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PORTS*PINS-1:0]   pin_in,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    irq
);
  localparam int NPIN   = PORTS * PINS;
  localparam int PSEL_W = $clog2(PORTS);

  logic [NPIN-1:0]   pin_sync;
  logic [3:0]        sel;
  logic [PSEL_W-1:0] pidx;
  logic [PINS-1:0]   st_arr   [PORTS];
  logic [PINS-1:0]   en_arr   [PORTS];
  logic [3*PINS-1:0] trig_arr [PORTS];
  logic [PORTS-1:0]  pend_vec;
  logic [PORTS-1:0]  any_en;
  logic [PORTS-1:0]  any_trig;

  assign sel  = bus_addr[ADDR_W-1 -: 4];
  assign pidx = bus_addr[PSEL_W-1:0];

  gpio_irq_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_port
      logic hit_p;
      assign hit_p       = bus_wr && (pidx == PSEL_W'(p));
      assign any_en[p]   = |en_arr[p];
      assign any_trig[p] = |trig_arr[p];

      gpio_irq_port #(.PINS(PINS), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst(rst),
        .pin_now(pin_sync[p*PINS +: PINS]),
        .we_en(hit_p && sel == SEL_ENABLE),
        .we_en_msk(hit_p && sel == SEL_EN_MASK),
        .we_trig(hit_p && sel == SEL_TRIG),
        .we_trig_msk(hit_p && sel == SEL_TRIG_MSK),
        .we_clr(hit_p && sel == SEL_CLEAR),
        .wdata(bus_wdata),
        .status(st_arr[p]), .enable(en_arr[p]), .trig(trig_arr[p]),
        .pend(pend_vec[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (sel)
        SEL_STATUS: bus_rdata <= DATA_W'(st_arr[pidx]);
        SEL_ENABLE: bus_rdata <= DATA_W'(en_arr[pidx]);
        SEL_TRIG:   bus_rdata <= DATA_W'(trig_arr[pidx]);
        default:    bus_rdata <= '0;
      endcase
    end
  end

  assign irq = |pend_vec;

  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|any_en));
  p_reset_clean_r11: assert property (@(posedge clk)
    rst |=> (!irq && any_en == '0 && any_trig == '0));
endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;

  localparam logic [3:0] S_STAT = 4'h4, S_EN = 4'h5, S_TRIG = 4'h6,
                         S_CLR = 4'h7, S_ENM = 4'hD, S_TRM = 4'hE;

  logic          clk = 1'b0;
  logic          rst;
  logic [31:0]   pin_in;
  logic          bus_wr, bus_rd;
  logic [5:0]    bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_seen = 1'b0;
  logic [DW-1:0] m_exp;
  string         m_tag;

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compare returned read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      m_exp = exp_q.pop_front();
      m_tag = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== m_exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", m_tag, bus_rdata, m_exp);
      end
    end
  end

  task automatic wr(input logic [3:0] s, input int p, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = {s, 2'(p)}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, input int p, input logic [DW-1:0] e, input string t);
    bus_rd = 1'b1; bus_addr = {s, 2'(p)};
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; pin_in = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    settle(3);
    rst = 1'b0;
    chk_irq(1'b0, "R11 reset");
    rd(S_EN, 0, 24'h0, "R11 enable after reset");
    rd(S_TRIG, 0, 24'h0, "R11 trigger after reset");

    // port0: pin0 rise, pin1 fall, pin2 both, pin3 high level, pins4-7 rise
    wr(S_TRIG, 0, 24'h04F7F9);
    rd(S_TRIG, 0, 24'h04F7F9, "R1 R12 trigger readback");
    wr(S_CLR, 0, 24'h0000FF);
    settle(2);
    rd(S_STAT, 0, 24'h00, "R6 status after clear");
    wr(S_EN, 0, 24'h000001);
    settle(2);
    chk_irq(1'b0, "R8 nothing pending");

    pin_in[0] = 1'b1; settle(5);
    rd(S_STAT, 0, 24'h01, "R2 rising sets");
    chk_irq(1'b1, "R8 enabled pending");
    pin_in[0] = 1'b0; settle(5);
    rd(S_STAT, 0, 24'h01, "R2 held after fall");
    wr(S_CLR, 0, 24'h000000); settle(2);
    rd(S_STAT, 0, 24'h01, "R6 zero write no effect");
    wr(S_CLR, 0, 24'h000001); settle(2);
    rd(S_STAT, 0, 24'h00, "R6 one clears");
    chk_irq(1'b0, "R8 drops after clear");

    pin_in[1] = 1'b1; settle(5);
    rd(S_STAT, 0, 24'h00, "R3 falling ignores rise");
    pin_in[1] = 1'b0; settle(5);
    rd(S_STAT, 0, 24'h02, "R3 falling sets");
    wr(S_CLR, 0, 24'h000002);

    pin_in[2] = 1'b1; settle(5);
    rd(S_STAT, 0, 24'h04, "R4 both on rise");
    wr(S_CLR, 0, 24'h000004);
    pin_in[2] = 1'b0; settle(5);
    rd(S_STAT, 0, 24'h04, "R4 both on fall");
    wr(S_CLR, 0, 24'h000004);

    pin_in[3] = 1'b1; settle(5);
    rd(S_STAT, 0, 24'h08, "R5 high level");
    wr(S_CLR, 0, 24'h000008); settle(2);
    rd(S_STAT, 0, 24'h08, "R5 clear while active");
    pin_in[3] = 1'b0; settle(5);
    rd(S_STAT, 0, 24'h00, "R5 level inactive");

    // clear racing a new rising edge on pin0
    pin_in[0] = 1'b1; settle(5);
    pin_in[0] = 1'b0; settle(5);
    pin_in[0] = 1'b1; settle(2);
    wr(S_CLR, 0, 24'h000001); settle(2);
    rd(S_STAT, 0, 24'h01, "R7 edge wins over clear");
    chk_irq(1'b1, "R7 irq kept");
    wr(S_CLR, 0, 24'h000001); settle(2);
    rd(S_STAT, 0, 24'h00, "R6 clear after race");

    wr(S_ENM, 0, 24'h000202);
    rd(S_EN, 0, 24'h03, "R9 masked set pin1");
    wr(S_ENM, 0, 24'h000100);
    rd(S_EN, 0, 24'h02, "R9 masked clear pin0");
    wr(S_ENM, 0, 24'h0000FF);
    rd(S_EN, 0, 24'h02, "R9 empty mask keeps");

    // port3 is low-level by default; pins are low
    rd(S_STAT, 3, 24'hFF, "R5 low level");
    wr(S_EN, 3, 24'h000080); settle(2);
    chk_irq(1'b1, "R8 other port");
    pin_in[31] = 1'b1; settle(5);
    rd(S_STAT, 3, 24'h7F, "R5 low level released");
    chk_irq(1'b0, "R8 other port released");

    wr(S_TRM, 0, 24'h000800);
    rd(S_TRIG, 0, 24'h04F7F1, "R10 masked polarity");
    settle(2);
    wr(S_STAT, 0, 24'h0000FF); settle(2);
    rd(S_STAT, 0, 24'h08, "R12 status write ignored");

    settle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule